// File: doc/BRIEF.md
# Interrupt Controller Base and Mode Register

This block keeps the 64-bit base and mode word of a local interrupt controller. The word holds the physical page of the controller's register window, a bootstrap-processor flag, a global enable bit and an extended-mode bit. Every write to it is checked before it lands. The check covers the permitted moves between the off, legacy and extended modes, and it covers the reserved bits. A rejected write leaves the word as it was and raises a one-cycle fault pulse.

The block also owns two access paths to the controller's registers. The first is a memory-mapped window decoded against the current base page, which serves only in legacy mode. The second is an indexed register path, which serves only in extended mode. Three registers sit behind these paths: a processor ID, a fixed version word and a task-priority mirror of the core's 4-bit priority. In off mode the window reads all ones, it accepts no writes, and the feature-present output drops.

Top module: `lic_base_ctl`

## Requirements
- R1: After reset the word reads 0x0000_0000_FEE0_0900: base page 0xFEE00, enable (bit 11) set, extended (bit 10) clear, bootstrap flag (bit 8) set. The fault output is low, feature-present is high and the priority is 0.
- R2: A write with bit 10 set and bit 11 clear always faults and leaves the word unchanged.
- R3: From extended mode (bits 11,10 = 1,1), a write to legacy mode (1,0) faults. A write to off mode (0,0) is accepted.
- R4: From off mode, a write to extended mode faults. Off to legacy and legacy to extended are accepted.
- R5: A write faults if it sets any bit at or above PA_W, bit 0, bits 7:1 or bit 9.
- R6: The fault output is high for exactly the one cycle after each rejected write. An accepted write updates the word on the same clock edge and gives no fault.
- R7: Outside legacy mode, window reads return 0xFFFF_FFFF and window writes change nothing. Feature-present equals bit 11 of the word.
- R8: The task-priority register (window offset 0x080, index 0x08) reads back as priority << 4. A write to it loads priority from data bits 7:4. The core-side priority write loads priority directly and wins over a register write in the same cycle.
- R9: The ID register (window offset 0x020, index 0x02) takes data bits 31:24 on a legacy window write and reads back in bits 31:24. On the extended path it reads back in bits 7:0, and a write to it faults and leaves the ID unchanged.
- R10: The window answers only when address bits PA_W-1:12 equal the base page, starting the cycle after an accepted base write. A miss reads 0xFFFF_FFFF. The version register sits at offset 0x030 (index 0x03), and any other offset reads 0.
- R11: An indexed-path write outside extended mode faults and is ignored. Indexed reads outside extended mode return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the base/mode word |
| cfg_wdata | input | 64 | Proposed base/mode word |
| cfg_rdata | output | 64 | Current base/mode word |
| cfg_fault | output | 1 | One-cycle pulse after a rejected write |
| feat_present | output | 1 | Controller present (enable bit) |
| win_wr | input | 1 | Window write strobe |
| win_addr | input | PA_W | Window physical address |
| win_wdata | input | 32 | Window write data |
| win_rdata | output | 32 | Window read data (combinational) |
| ext_wr | input | 1 | Indexed-path write strobe |
| ext_idx | input | 8 | Indexed-path register index (offset >> 4) |
| ext_wdata | input | 32 | Indexed-path write data |
| ext_rdata | output | 32 | Indexed-path read data (combinational) |
| prio_wr | input | 1 | Core-side priority write |
| prio_wdata | input | 4 | Core-side priority value |
| prio_q | output | 4 | Current 4-bit priority |

## Verification
Two things can fall in the same cycle: a core-side priority write and a task-priority write through the window. The bench drives both on one edge with different values and expects the core value in both the priority output and the window readback. It also puts a base write in the same cycle as a window access, and expects the access to decode against the old base and mode while the new ones serve from the next cycle. Random base/mode writes with occasional reserved bits are checked against a bench model of the transition rules.

// File: rtl/lic_pkg.sv
package lic_pkg;

    // mode encoding is {enable, extended}
    typedef enum logic [1:0] {
        MODE_OFF = 2'b00,
        MODE_BAD = 2'b01,
        MODE_LEG = 2'b10,
        MODE_EXT = 2'b11
    } lic_mode_e;

    localparam int BIT_BSP  = 8;
    localparam int BIT_EXT  = 10;
    localparam int BIT_EN   = 11;
    localparam int PAGE_LSB = 12;

    localparam logic [7:0] IDX_ID  = 8'h02;
    localparam logic [7:0] IDX_VER = 8'h03;
    localparam logic [7:0] IDX_TPR = 8'h08;

    typedef struct packed {
        logic       tpr_wr;
        logic [3:0] tpr_val;
        logic       id_wr;
        logic [7:0] id_val;
        logic       fault;
    } lic_upd_t;

    function automatic lic_mode_e mode_of(input logic [63:0] v);
        return lic_mode_e'({v[BIT_EN], v[BIT_EXT]});
    endfunction

    // permitted moves between modes
    function automatic logic edge_ok(input lic_mode_e cur, input lic_mode_e nxt);
        case (nxt)
            MODE_OFF: return 1'b1;
            MODE_LEG: return cur != MODE_EXT;
            MODE_EXT: return cur == MODE_LEG || cur == MODE_EXT;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] reg_read(input logic [7:0] idx, input logic ext_fmt,
                                             input logic [7:0] id, input logic [3:0] prio,
                                             input logic [31:0] version);
        case (idx)
            IDX_ID:  return ext_fmt ? {24'h0, id} : {id, 24'h0};
            IDX_VER: return version;
            IDX_TPR: return {24'h0, prio, 4'h0};
            default: return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/lic_mode_reg.sv
module lic_mode_reg
    import lic_pkg::*;
#(
    parameter int          PA_W      = 36,
    parameter logic [63:0] RESET_VAL = 64'h0000_0000_FEE0_0900
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [63:0] wdata,
    output logic [63:0] q,
    output logic        reject
);
    localparam logic [63:0] ADDR_MASK = (PA_W >= 64) ? '1 : ((64'd1 << PA_W) - 64'd1);
    localparam logic [63:0] RSVD_MASK = ~ADDR_MASK | 64'h0000_0000_0000_02FF;

    logic rsvd_hit;
    logic bad_edge;

    always_comb begin
        rsvd_hit = (wdata & RSVD_MASK) != 64'h0;
        bad_edge = !edge_ok(mode_of(q), mode_of(wdata));
        reject   = wr && (rsvd_hit || bad_edge);
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= RESET_VAL;
        else if (wr && !reject)
            q <= wdata;
    end
endmodule

// File: rtl/lic_prio_id.sv
module lic_prio_id #(
    parameter logic [7:0] ID_INIT = 8'h00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       core_wr,
    input  logic [3:0] core_val,
    input  logic       tpr_wr,
    input  logic [3:0] tpr_val,
    input  logic       id_wr,
    input  logic [7:0] id_val,
    output logic [3:0] prio,
    output logic [7:0] id
);
    always_ff @(posedge clk) begin
        if (rst) begin
            prio <= 4'h0;
            id   <= ID_INIT;
        end else begin
            if (core_wr)
                prio <= core_val;
            else if (tpr_wr)
                prio <= tpr_val;
            if (id_wr)
                id <= id_val;
        end
    end
endmodule

// File: rtl/lic_port_dec.sv
module lic_port_dec
    import lic_pkg::*;
#(
    parameter int          PA_W    = 36,
    parameter logic [31:0] VERSION = 32'h0005_0014
) (
    input  lic_mode_e        mode,
    input  logic [63:0]      base,
    input  logic             win_wr,
    input  logic [PA_W-1:0]  win_addr,
    input  logic [31:0]      win_wdata,
    input  logic             ext_wr,
    input  logic [7:0]       ext_idx,
    input  logic [31:0]      ext_wdata,
    input  logic [7:0]       id,
    input  logic [3:0]       prio,
    output logic [31:0]      win_rdata,
    output logic [31:0]      ext_rdata,
    output lic_upd_t         upd
);
    localparam int PAGE_W = PA_W - PAGE_LSB;

    logic [PAGE_W-1:0] page_req;
    logic [PAGE_W-1:0] page_cur;
    logic              win_live;
    logic              ext_live;
    logic [7:0]        win_idx;

    always_comb begin
        page_req  = win_addr[PA_W-1:PAGE_LSB];
        page_cur  = base[PA_W-1:PAGE_LSB];
        win_idx   = win_addr[11:4];
        win_live  = (mode == MODE_LEG) && (page_req == page_cur);
        ext_live  = (mode == MODE_EXT);

        win_rdata = win_live ? reg_read(win_idx, 1'b0, id, prio, VERSION) : 32'hFFFF_FFFF;
        ext_rdata = ext_live ? reg_read(ext_idx, 1'b1, id, prio, VERSION) : 32'h0;

        upd = '0;
        if (win_wr && win_live) begin
            if (win_idx == IDX_TPR) begin
                upd.tpr_wr  = 1'b1;
                upd.tpr_val = win_wdata[7:4];
            end
            if (win_idx == IDX_ID) begin
                upd.id_wr  = 1'b1;
                upd.id_val = win_wdata[31:24];
            end
        end
        if (ext_wr) begin
            if (!ext_live || ext_idx == IDX_ID) begin
                upd.fault = 1'b1;
            end else if (ext_idx == IDX_TPR) begin
                upd.tpr_wr  = 1'b1;
                upd.tpr_val = ext_wdata[7:4];
            end
        end
    end
endmodule

// File: rtl/lic_base_ctl.sv
module lic_base_ctl
    import lic_pkg::*;
#(
    parameter int          PA_W      = 36,
    parameter logic [63:0] RESET_VAL = 64'h0000_0000_FEE0_0900,
    parameter logic [7:0]  ID_INIT   = 8'h00,
    parameter logic [31:0] VERSION   = 32'h0005_0014
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_wr,
    input  logic [63:0]     cfg_wdata,
    output logic [63:0]     cfg_rdata,
    output logic            cfg_fault,
    output logic            feat_present,
    input  logic            win_wr,
    input  logic [PA_W-1:0] win_addr,
    input  logic [31:0]     win_wdata,
    output logic [31:0]     win_rdata,
    input  logic            ext_wr,
    input  logic [7:0]      ext_idx,
    input  logic [31:0]     ext_wdata,
    output logic [31:0]     ext_rdata,
    input  logic            prio_wr,
    input  logic [3:0]      prio_wdata,
    output logic [3:0]      prio_q
);
    logic [63:0] word_q;
    logic        word_reject;
    lic_upd_t    upd;
    logic [7:0]  id_q;
    logic        fault_q;

    lic_mode_reg #(.PA_W(PA_W), .RESET_VAL(RESET_VAL)) u_mode (
        .clk    (clk),
        .rst    (rst),
        .wr     (cfg_wr),
        .wdata  (cfg_wdata),
        .q      (word_q),
        .reject (word_reject)
    );

    lic_port_dec #(.PA_W(PA_W), .VERSION(VERSION)) u_dec (
        .mode      (mode_of(word_q)),
        .base      (word_q),
        .win_wr    (win_wr),
        .win_addr  (win_addr),
        .win_wdata (win_wdata),
        .ext_wr    (ext_wr),
        .ext_idx   (ext_idx),
        .ext_wdata (ext_wdata),
        .id        (id_q),
        .prio      (prio_q),
        .win_rdata (win_rdata),
        .ext_rdata (ext_rdata),
        .upd       (upd)
    );

    lic_prio_id #(.ID_INIT(ID_INIT)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .core_wr  (prio_wr),
        .core_val (prio_wdata),
        .tpr_wr   (upd.tpr_wr),
        .tpr_val  (upd.tpr_val),
        .id_wr    (upd.id_wr),
        .id_val   (upd.id_val),
        .prio     (prio_q),
        .id       (id_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            fault_q <= 1'b0;
        else
            fault_q <= word_reject | upd.fault;
    end

    assign cfg_rdata    = word_q;
    assign cfg_fault    = fault_q;
    assign feat_present = word_q[BIT_EN];
endmodule

// File: rtl/lic_base_ctl_chk.sv
module lic_base_ctl_chk #(
    parameter int PA_W = 36
) (
    input logic        clk,
    input logic        rst,
    input logic        cfg_wr,
    input logic        ext_wr,
    input logic [63:0] cfg_rdata,
    input logic        cfg_fault,
    input logic [31:0] win_rdata
);
    // R6: a fault only follows a write attempt
    assert_fault_has_cause_R6: assert property (@(posedge clk) disable iff (rst)
        cfg_fault |-> $past(cfg_wr || ext_wr));

    // R2: a rejected word write leaves the word unchanged
    assert_reject_keeps_word_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_fault && $past(cfg_wr) && !$past(ext_wr)) |-> $stable(cfg_rdata));

    // R2: the word never holds extended without enable
    assert_no_bad_mode_R2: assert property (@(posedge clk) disable iff (rst)
        !(cfg_rdata[10] && !cfg_rdata[11]));

    // R3: extended never moves straight to legacy
    assert_no_ext_to_leg_R3: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_rdata[10]) |-> (cfg_rdata[10] || !cfg_rdata[11]));

    // R4: off never moves straight to extended
    assert_no_off_to_ext_R4: assert property (@(posedge clk) disable iff (rst)
        $past(!cfg_rdata[11]) |-> !cfg_rdata[10]);

    // R5: reserved bits never held
    assert_rsvd_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata >> PA_W) == 64'h0 && cfg_rdata[0] == 1'b0);

    // R7: disabled controller window reads all ones
    assert_off_reads_ones_R7: assert property (@(posedge clk) disable iff (rst)
        !cfg_rdata[11] |-> win_rdata == 32'hFFFF_FFFF);
endmodule

bind lic_base_ctl lic_base_ctl_chk #(.PA_W(PA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .ext_wr    (ext_wr),
    .cfg_rdata (cfg_rdata),
    .cfg_fault (cfg_fault),
    .win_rdata (win_rdata)
);

// File: tb/lic_base_ctl_bench.sv
`timescale 1ns/1ps
module lic_base_ctl_bench;
    localparam int PA_W = 36;
    localparam logic [31:0] VER = 32'h0005_0014;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_wr = 1'b0;
    logic [63:0]     cfg_wdata = '0;
    logic [63:0]     cfg_rdata;
    logic            cfg_fault;
    logic            feat_present;
    logic            win_wr = 1'b0;
    logic [PA_W-1:0] win_addr = '0;
    logic [31:0]     win_wdata = '0;
    logic [31:0]     win_rdata;
    logic            ext_wr = 1'b0;
    logic [7:0]      ext_idx = '0;
    logic [31:0]     ext_wdata = '0;
    logic [31:0]     ext_rdata;
    logic            prio_wr = 1'b0;
    logic [3:0]      prio_wdata = '0;
    logic [3:0]      prio_q;

    int checks = 0;
    int errors = 0;
    logic [63:0] mword;
    logic        fres;

    always #2 clk = ~clk;

    lic_base_ctl #(.PA_W(PA_W)) u_lic_base_ctl (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_fault(cfg_fault), .feat_present(feat_present),
        .win_wr(win_wr), .win_addr(win_addr), .win_wdata(win_wdata), .win_rdata(win_rdata),
        .ext_wr(ext_wr), .ext_idx(ext_idx), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
        .prio_wr(prio_wr), .prio_wdata(prio_wdata), .prio_q(prio_q)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected legality from the requirements
    function automatic logic write_ok(input logic [63:0] cur, input logic [63:0] nv);
        logic [63:0] rsvd;
        logic [1:0]  c, n;
        rsvd = ~((64'd1 << PA_W) - 64'd1) | 64'h2FF;
        c = {cur[11], cur[10]};
        n = {nv[11], nv[10]};
        if ((nv & rsvd) != 0) return 1'b0;
        if (n == 2'b01) return 1'b0;
        if (c == 2'b11 && n == 2'b10) return 1'b0;
        if (c == 2'b00 && n == 2'b11) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [PA_W-1:0] page_addr(input logic [63:0] w, input logic [11:0] off);
        return {w[PA_W-1:12], off};
    endfunction

    task automatic cfg_write(input logic [63:0] v, output logic f);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        f = cfg_fault;
        cfg_wr = 1'b0;
    endtask

    task automatic model_write(input string tag, input logic [63:0] v);
        logic ok;
        logic f;
        ok = write_ok(mword, v);
        cfg_write(v, f);
        if (ok) mword = v;
        check({tag, " fault"}, {63'h0, f}, {63'h0, !ok});
        check({tag, " word"}, cfg_rdata, mword);
    endtask

    task automatic win_read(input logic [PA_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        win_addr = a;
        #1 d = win_rdata;
    endtask

    task automatic win_write(input logic [PA_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        win_addr = a;
        win_wdata = d;
        win_wr = 1'b1;
        @(negedge clk);
        win_wr = 1'b0;
    endtask

    task automatic ext_write(input logic [7:0] i, input logic [31:0] d, output logic f);
        @(negedge clk);
        ext_idx = i;
        ext_wdata = d;
        ext_wr = 1'b1;
        @(negedge clk);
        f = cfg_fault;
        ext_wr = 1'b0;
    endtask

    task automatic ext_read(input logic [7:0] i, output logic [31:0] d);
        @(negedge clk);
        ext_idx = i;
        #1 d = ext_rdata;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [63:0] v;
        logic [63:0] leg_def;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        mword = 64'h0000_0000_FEE0_0900;
        leg_def = mword;

        // R1 reset state
        check("R1 word", cfg_rdata, 64'h0000_0000_FEE0_0900);
        check("R1 fault", {63'h0, cfg_fault}, 64'h0);
        check("R1 present", {63'h0, feat_present}, 64'h1);
        check("R1 prio", {60'h0, prio_q}, 64'h0);

        // R10 version at default base, unknown offset reads 0
        win_read(page_addr(mword, 12'h030), d);
        check("R10 version", {32'h0, d}, {32'h0, VER});
        win_read(page_addr(mword, 12'h040), d);
        check("R10 other offset", {32'h0, d}, 64'h0);

        // R8 priority mirror
        @(negedge clk); prio_wr = 1'b1; prio_wdata = 4'h5;
        @(negedge clk); prio_wr = 1'b0;
        win_read(page_addr(mword, 12'h080), d);
        check("R8 tpr read", {32'h0, d}, 64'h50);
        win_write(page_addr(mword, 12'h080), 32'h0000_00A7);
        check("R8 tpr write", {60'h0, prio_q}, 64'hA);
        // R8 collision: core write and window write in the same cycle
        @(negedge clk);
        prio_wr = 1'b1; prio_wdata = 4'h3;
        win_addr = page_addr(mword, 12'h080); win_wdata = 32'hC0; win_wr = 1'b1;
        @(negedge clk);
        prio_wr = 1'b0; win_wr = 1'b0;
        check("R8 collision prio", {60'h0, prio_q}, 64'h3);
        win_read(page_addr(mword, 12'h080), d);
        check("R8 collision read", {32'h0, d}, 64'h30);

        // R9 legacy ID
        win_write(page_addr(mword, 12'h020), 32'h0700_0000);
        win_read(page_addr(mword, 12'h020), d);
        check("R9 legacy id", {32'h0, d}, 64'h0700_0000);

        // R2 invalid mode, R5 reserved bits
        model_write("R2 ext without enable", (mword & ~64'h800) | 64'h400);
        model_write("R5 bit at PA_W", mword | (64'd1 << PA_W));
        model_write("R5 bit 0", mword | 64'h1);
        model_write("R5 bit 9", mword | 64'h200);
        // R6 pulse drops with no write
        @(negedge clk);
        check("R6 single pulse", {63'h0, cfg_fault}, 64'h0);

        // R11 indexed path outside extended mode
        ext_write(8'h08, 32'hF0, fres);
        check("R11 ext write faults", {63'h0, fres}, 64'h1);
        check("R11 ext write ignored", {60'h0, prio_q}, 64'h3);
        ext_read(8'h03, d);
        check("R11 ext read zero", {32'h0, d}, 64'h0);

        // R4 legacy to extended allowed
        model_write("R4 leg to ext", mword | 64'h400);
        ext_read(8'h02, d);
        check("R9 ext id format", {32'h0, d}, 64'h07);
        ext_write(8'h02, 32'h0900_0009, fres);
        check("R9 ext id write faults", {63'h0, fres}, 64'h1);
        ext_read(8'h02, d);
        check("R9 ext id unchanged", {32'h0, d}, 64'h07);
        ext_write(8'h08, 32'h90, fres);
        check("R8 ext tpr no fault", {63'h0, fres}, 64'h0);
        check("R8 ext tpr write", {60'h0, prio_q}, 64'h9);
        win_read(page_addr(mword, 12'h030), d);
        check("R7 ext window ones", {32'h0, d}, 64'hFFFF_FFFF);
        model_write("R3 ext to leg", mword & ~64'h400);
        model_write("R3 ext to off", mword & ~64'hC00);

        // R7 off mode
        check("R7 present low", {63'h0, feat_present}, 64'h0);
        win_read(page_addr(mword, 12'h080), d);
        check("R7 off reads ones", {32'h0, d}, 64'hFFFF_FFFF);
        win_write(page_addr(mword, 12'h080), 32'h10);
        check("R7 off write ignored", {60'h0, prio_q}, 64'h9);
        model_write("R4 off to ext", mword | 64'hC00);

        // R10 relocation, and R4 off to legacy
        model_write("R4 off to leg relocated", 64'h0000_0000_4200_0900);
        win_read(36'h0_4200_0030, d);
        check("R10 relocated hit", {32'h0, d}, {32'h0, VER});
        win_read(36'h0_FEE0_0030, d);
        check("R10 old base miss", {32'h0, d}, 64'hFFFF_FFFF);
        // R10 same-cycle base write and window access uses old base
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = leg_def;
        win_addr = 36'h0_4200_0030;
        #1 d = win_rdata;
        check("R10 old base during write", {32'h0, d}, {32'h0, VER});
        @(negedge clk);
        cfg_wr = 1'b0;
        mword = leg_def;
        #1 d = win_rdata;
        check("R10 new base next cycle", {32'h0, d}, 64'hFFFF_FFFF);

        // random base/mode writes against the model
        for (int i = 0; i < 400; i++) begin
            int pick;
            v = '0;
            v[PA_W-1:12] = {$urandom, $urandom};
            v[8]  = 1'($urandom);
            v[10] = 1'($urandom);
            v[11] = ($urandom % 4) != 0;
            pick = int'($urandom % 8);
            if (pick == 0) v[PA_W + int'($urandom % (64 - PA_W))] = 1'b1;
            else if (pick == 1) v[0] = 1'b1;
            else if (pick == 2) v[int'($urandom % 8)] = 1'b1;
            else if (pick == 3) v[9] = 1'b1;
            model_write("R2 R3 R4 R5 R6 random", v);
            check("R7 random present", {63'h0, feat_present}, {63'h0, mword[11]});
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule